// File: doc/BRIEF.md
# DDR3 Command Scheduler with Per-Bank Row Tracking

This block sits between a request source and the DDR3 command pins. Each request names a bank, a row, a column, a direction (read or write) and an optional auto-precharge flag. Requests arrive through a valid/ready handshake. The block turns each request into the shortest legal command sequence for the current state of the target bank. It keeps a table of eight entries. Each entry records whether a row is open in that bank and, if so, which row.

Requests pass through two stages. A holding register can accept the next request while the executor is still driving commands for the current one. Only the commands issued by the executor update the bank table. A request in the holding register is classified against that table only when the executor takes it over. A single gap timer spaces consecutive commands by fixed minimum intervals, counted in controller clocks.

A periodic refresh request is served only between requests. If any bank is open, the block first closes all banks with one precharge. It then issues REFRESH and blocks further commands for the refresh recovery time.

Top module: `ddr3_cmd_sched`

## Requirements
- R1: While rst_ni is low, cke_o is 0 and the four command pins are all 1. From the first clock after reset, cke_o stays 1, the pins idle as NOP and req_ready_o is 1.
- R2: Commands are encoded on {cs_n_o, ras_n_o, cas_n_o, we_n_o} as follows: ACT=0011, READ=0101, WRITE=0100, PRECHARGE=0010, REFRESH=0001 and NOP=0111. No other code is driven while cke_o is 1 and cs_n_o is 0.
- R3: A request to a closed bank issues ACT with the bank on ba_o and the row on addr_o[ROW_W-1:0]. The column command follows exactly T_RCD cycles later.
- R4: A request whose row matches the open row of its bank issues only the column command.
- R5: A request to a bank that has a different row open issues PRECHARGE to that bank with addr_o[10]=0. ACT follows exactly T_RP cycles later, and the column command comes T_RCD cycles after the ACT.
- R6: A column command carries the column on addr_o[COL_W-1:0] and the auto-precharge flag on addr_o[10]. It is WRITE when req_write_i was 1 and READ otherwise.
- R7: After a column command with auto-precharge, the bank counts as closed, so the next access to it starts with ACT. The next command of any kind comes no sooner than T_COL+T_RP cycles after it.
- R8: The gap between consecutive commands is at least T_RCD after ACT, T_RP after PRECHARGE, T_COL after a column command and T_RFC after REFRESH.
- R9: ref_req_i is acted on only once the current request has issued its column command. If any bank is open, the block issues PRECHARGE with addr_o[10]=1 and ba_o=0, then REFRESH T_RP cycles later. Otherwise it issues REFRESH at once. REFRESH has ba_o=0 and addr_o=0, and ref_ack_o is 1 in exactly the cycle REFRESH is on the pins. Afterwards every bank is closed.
- R10: One request can be accepted while another is being executed. Requests execute in the order they were accepted.
- R11: The open/closed state and the open row are kept separately for each bank. Opening or closing a row in one bank does not change how requests to other banks are classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted at this edge when valid |
| req_bank_i | input | BA_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Starting column |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_autopre_i | input | 1 | Close the row after the burst |
| ref_req_i | input | 1 | Refresh request, held until acknowledged |
| ref_ack_o | output | 1 | High in the cycle REFRESH is driven |
| cke_o | output | 1 | Clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Row/column address, bit 10 = precharge-all / auto-precharge |

## Verification
Every bank is swept through four request patterns in turn: first touch of a closed bank, a repeat to the same row, a different row with auto-precharge on alternate banks, and a return to those banks. Each pattern separates a different classification path: ACT then column, column only, PRECHARGE then ACT then column, and ACT after a self-closing access. Refresh is raised twice: once just after a request has started, with banks open, and once with everything closed. These two cases separate the wait for the current request, the conditional precharge-all and the cleared table. Every observed command is compared with an independently kept bank model, and the spacing between commands is checked against the minimum and exact gaps.

// File: rtl/ddr3_sched_pkg.sv
package ddr3_sched_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_ACT, ST_COL, ST_PREA, ST_REF
  } st_e;
endpackage

// File: rtl/ddr3_bank_table.sv
module ddr3_bank_table #(
  parameter int NB    = 8,
  parameter int BA_W  = 3,
  parameter int ROW_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic [BA_W-1:0]  open_bank_i,
  input  logic [ROW_W-1:0] open_row_i,
  input  logic             close_i,
  input  logic [BA_W-1:0]  close_bank_i,
  input  logic             close_all_i,
  input  logic [BA_W-1:0]  look_bank_i,
  output logic             look_open_o,
  output logic [ROW_W-1:0] look_row_o,
  output logic             any_open_o
);
  logic [NB-1:0]    open_q;
  logic [ROW_W-1:0] row_q [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic             open_r;
    logic [ROW_W-1:0] row_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_r <= 1'b0;
        row_r  <= '0;
      end else if (close_all_i || (close_i && close_bank_i == BA_W'(g))) begin
        open_r <= 1'b0;
      end else if (open_i && open_bank_i == BA_W'(g)) begin
        open_r <= 1'b1;
        row_r  <= open_row_i;
      end
    end
    assign open_q[g] = open_r;
    assign row_q[g]  = row_r;
  end

  assign look_open_o = open_q[look_bank_i];
  assign look_row_o  = row_q[look_bank_i];
  assign any_open_o  = |open_q;
endmodule

// File: rtl/ddr3_gap_timer.sv
module ddr3_gap_timer #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          idle_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign idle_o = (cnt_q == '0);
endmodule

// File: rtl/ddr3_req_stage.sv
module ddr3_req_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  input  logic         pop_i
);
  logic         valid_q;
  logic [W-1:0] data_q;

  assign ready_o = !valid_q || pop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (valid_i && ready_o) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (pop_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/ddr3_cmd_sched.sv
module ddr3_cmd_sched
  import ddr3_sched_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,  // must stay <= 10, bit 10 carries the precharge flag
  parameter int ADDR_W    = 14,  // must cover ROW_W and bit 10
  parameter int T_RCD     = 3,
  parameter int T_RP      = 4,
  parameter int T_RFC     = 12,
  parameter int T_COL     = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BA_W-1:0]   req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_write_i,
  input  logic              req_autopre_i,
  input  logic              ref_req_i,
  output logic              ref_ack_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int GAP_MAX = T_RFC + T_RCD + T_RP + T_COL;
  localparam int CW      = $clog2(GAP_MAX + 1);

  typedef struct packed {
    logic [BA_W-1:0]  bank;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic             wr;
    logic             ap;
  } req_t;
  localparam int REQ_W = $bits(req_t);

  req_t             in_req, a_req, cur_q;
  logic [REQ_W-1:0] a_data;
  logic             a_valid, take;
  st_e              st_q, st_d;
  cmd_e             cmd_d;
  logic [BA_W-1:0]  ba_d;
  logic [ADDR_W-1:0] addr_d;
  logic [CW-1:0]    gap;
  logic             gap_idle, issue, ref_ack_d;
  logic             bt_open, bt_close, bt_close_all;
  logic             look_open, any_open;
  logic [ROW_W-1:0] look_row;

  assign in_req = '{bank: req_bank_i, row: req_row_i, col: req_col_i,
                    wr: req_write_i, ap: req_autopre_i};
  assign a_req  = req_t'(a_data);

  // decode stage: holds the next request while the executor drives the bus
  ddr3_req_stage #(.W(REQ_W)) u_stage (
    .clk_i, .rst_ni,
    .valid_i (req_valid_i),
    .ready_o (req_ready_o),
    .data_i  (in_req),
    .valid_o (a_valid),
    .data_o  (a_data),
    .pop_i   (take)
  );

  ddr3_bank_table #(.NB(NUM_BANKS), .BA_W(BA_W), .ROW_W(ROW_W)) u_banks (
    .clk_i, .rst_ni,
    .open_i       (bt_open),
    .open_bank_i  (cur_q.bank),
    .open_row_i   (cur_q.row),
    .close_i      (bt_close),
    .close_bank_i (cur_q.bank),
    .close_all_i  (bt_close_all),
    .look_bank_i  (a_req.bank),
    .look_open_o  (look_open),
    .look_row_o   (look_row),
    .any_open_o   (any_open)
  );

  ddr3_gap_timer #(.CW(CW)) u_gap (
    .clk_i, .rst_ni,
    .load_i     (issue),
    .load_val_i (gap - CW'(1)),
    .idle_o     (gap_idle)
  );

  always_comb begin
    st_d         = st_q;
    cmd_d        = CMD_NOP;
    ba_d         = '0;
    addr_d       = '0;
    gap          = CW'(1);
    take         = 1'b0;
    bt_open      = 1'b0;
    bt_close     = 1'b0;
    bt_close_all = 1'b0;
    ref_ack_d    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ref_req_i) begin
          st_d = any_open ? ST_PREA : ST_REF;
        end else if (a_valid) begin
          take = 1'b1;
          if (!look_open)                st_d = ST_ACT;
          else if (look_row == a_req.row) st_d = ST_COL;
          else                           st_d = ST_PRE;
        end
      end
      ST_PRE: if (gap_idle) begin
        cmd_d    = CMD_PRE;
        ba_d     = cur_q.bank;
        gap      = CW'(T_RP);
        bt_close = 1'b1;
        st_d     = ST_ACT;
      end
      ST_ACT: if (gap_idle) begin
        cmd_d                = CMD_ACT;
        ba_d                 = cur_q.bank;
        addr_d[ROW_W-1:0]    = cur_q.row;
        gap                  = CW'(T_RCD);
        bt_open              = 1'b1;
        st_d                 = ST_COL;
      end
      ST_COL: if (gap_idle) begin
        cmd_d             = cur_q.wr ? CMD_WR : CMD_RD;
        ba_d              = cur_q.bank;
        addr_d[COL_W-1:0] = cur_q.col;
        addr_d[10]        = cur_q.ap;
        gap               = cur_q.ap ? CW'(T_COL + T_RP) : CW'(T_COL);
        bt_close          = cur_q.ap;
        st_d              = ST_IDLE;
      end
      ST_PREA: if (gap_idle) begin
        cmd_d        = CMD_PRE;
        addr_d[10]   = 1'b1;
        gap          = CW'(T_RP);
        bt_close_all = 1'b1;
        st_d         = ST_REF;
      end
      ST_REF: if (gap_idle) begin
        cmd_d     = CMD_REF;
        gap       = CW'(T_RFC);
        ref_ack_d = 1'b1;
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign issue = (cmd_d != CMD_NOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
    end else begin
      st_q <= st_d;
      if (take) cur_q <= a_req;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b1111;
      cke_o     <= 1'b0;
      ba_o      <= '0;
      addr_o    <= '0;
      ref_ack_o <= 1'b0;
    end else begin
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= cmd_d;
      cke_o     <= 1'b1;
      ba_o      <= ba_d;
      addr_o    <= addr_d;
      ref_ack_o <= ref_ack_d;
    end
  end
endmodule

// File: rtl/ddr3_cmd_sched_chk.sv
module ddr3_cmd_sched_chk
  import ddr3_sched_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 4,
  parameter int T_RFC = 12,
  parameter int T_COL = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cke_i,
  input logic cs_n_i,
  input logic ras_n_i,
  input logic cas_n_i,
  input logic we_n_i,
  input logic a10_i,
  input logic ref_ack_i
);
  localparam int SW = $clog2(T_RFC + T_RCD + T_RP + T_COL + 2) + 1;

  logic [3:0]    code;
  logic          is_cmd, seen_q;
  logic [SW-1:0] since_q, need_q, need_d;

  assign code   = {cs_n_i, ras_n_i, cas_n_i, we_n_i};
  assign is_cmd = cke_i && !cs_n_i && (code != CMD_NOP);

  always_comb begin
    case (code)
      CMD_ACT:        need_d = SW'(T_RCD);
      CMD_PRE:        need_d = SW'(T_RP);
      CMD_REF:        need_d = SW'(T_RFC);
      CMD_RD, CMD_WR: need_d = a10_i ? SW'(T_COL + T_RP) : SW'(T_COL);
      default:        need_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      since_q <= '0;
      need_q  <= '0;
    end else if (is_cmd) begin
      seen_q  <= 1'b1;
      since_q <= SW'(1);
      need_q  <= need_d;
    end else if (since_q != '1) begin
      since_q <= since_q + 1'b1;
    end
  end

  assert_min_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && seen_q) |-> (since_q >= need_q));

  assert_legal_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && !cs_n_i) |-> (code == CMD_ACT || code == CMD_RD || code == CMD_WR ||
                            code == CMD_PRE || code == CMD_REF || code == CMD_NOP));

  assert_cke_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i |=> cke_i);

  assert_ack_is_ref_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ack_i |-> (is_cmd && code == CMD_REF));

  assert_ref_has_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && code == CMD_REF) |-> ref_ack_i);
endmodule

bind ddr3_cmd_sched ddr3_cmd_sched_chk #(
  .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_COL(T_COL)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cke_i     (cke_o),
  .cs_n_i    (cs_n_o),
  .ras_n_i   (ras_n_o),
  .cas_n_i   (cas_n_o),
  .we_n_i    (we_n_o),
  .a10_i     (addr_o[10]),
  .ref_ack_i (ref_ack_o)
);

// File: tb/ddr3_cmd_sched_tb_top.sv
module ddr3_cmd_sched_tb_top;
  localparam int T_RCD = 3;
  localparam int T_RP  = 4;
  localparam int T_RFC = 12;
  localparam int T_COL = 2;
  localparam int C_REF = 1, C_PRE = 2, C_ACT = 3, C_WR = 4, C_RD = 5, C_NOP = 7;
  localparam int MAXN = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        req_write = 1'b0;
  logic        req_ap = 1'b0;
  logic        ref_req = 1'b0;
  logic        ref_ack, cke, cs_n, ras_n, cas_n, we_n;
  logic [2:0]  ba;
  logic [13:0] addr;

  always #10 clk = ~clk;

  ddr3_cmd_sched #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_COL(T_COL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .req_write_i(req_write), .req_autopre_i(req_ap),
    .ref_req_i(ref_req), .ref_ack_o(ref_ack),
    .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int obs_n = 0, exp_n = 0, done_idx = 0;
  int obs_code [MAXN], obs_ba [MAXN], obs_addr [MAXN], obs_cyc [MAXN];
  int exp_code [MAXN], exp_ba [MAXN], exp_addr [MAXN], exp_exact [MAXN];
  bit m_open [8];
  int m_row [8];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && cke && !cs_n && {cs_n, ras_n, cas_n, we_n} != 4'(C_NOP) && obs_n < MAXN) begin
      obs_code[obs_n] = int'({cs_n, ras_n, cas_n, we_n});
      obs_ba[obs_n]   = int'(ba);
      obs_addr[obs_n] = int'(addr);
      obs_cyc[obs_n]  = cyc;
      obs_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int min_gap(input int code, input int a);
    case (code)
      C_ACT: return T_RCD;
      C_PRE: return T_RP;
      C_REF: return T_RFC;
      C_RD, C_WR: return T_COL + (((a >> 10) & 1) != 0 ? T_RP : 0);
      default: return 0;
    endcase
  endfunction

  task automatic push(input int code, input int b, input int a, input int exact);
    exp_code[exp_n] = code; exp_ba[exp_n] = b; exp_addr[exp_n] = a; exp_exact[exp_n] = exact;
    exp_n++;
  endtask

  task automatic model_req(input int b, input int row, input int col, input bit wr, input bit ap);
    int ccode = wr ? C_WR : C_RD;
    int caddr = col | (ap ? 1024 : 0);
    if (!m_open[b]) begin
      push(C_ACT, b, row, 0);
      push(ccode, b, caddr, T_RCD);
    end else if (m_row[b] == row) begin
      push(ccode, b, caddr, 0);
    end else begin
      push(C_PRE, b, 0, 0);
      push(C_ACT, b, row, T_RP);
      push(ccode, b, caddr, T_RCD);
    end
    m_open[b] = !ap;
    m_row[b]  = row;
  endtask

  task automatic model_ref();
    bit any = 1'b0;
    for (int i = 0; i < 8; i++) any |= m_open[i];
    if (any) begin
      push(C_PRE, 0, 1024, 0);
      push(C_REF, 0, 0, T_RP);
    end else begin
      push(C_REF, 0, 0, 0);
    end
    for (int i = 0; i < 8; i++) m_open[i] = 1'b0;
  endtask

  task automatic send(input int b, input int row, input int col, input bit wr, input bit ap);
    @(negedge clk);
    req_valid = 1'b1; req_bank = 3'(b); req_row = 13'(row); req_col = 10'(col);
    req_write = wr; req_ap = ap;
    while (!req_ready) @(negedge clk);
    model_req(b, row, col, wr, ap);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic verify(input string req);
    repeat (80) @(negedge clk);
    chk(obs_n == exp_n, "R10", "command count", obs_n, exp_n);
    for (int i = done_idx; i < exp_n && i < obs_n; i++) begin
      chk(obs_code[i] == exp_code[i], "R2", {req, " command code"}, obs_code[i], exp_code[i]);
      chk(obs_ba[i] == exp_ba[i], req, "bank", obs_ba[i], exp_ba[i]);
      chk(obs_addr[i] == exp_addr[i], "R6", {req, " address"}, obs_addr[i], exp_addr[i]);
      if (i > 0) begin
        int g = obs_cyc[i] - obs_cyc[i-1];
        chk(g >= min_gap(obs_code[i-1], obs_addr[i-1]), "R8", "minimum gap", g,
            min_gap(obs_code[i-1], obs_addr[i-1]));
        if (exp_exact[i] != 0) chk(g == exp_exact[i], req, "exact gap", g, exp_exact[i]);
      end
    end
    done_idx = exp_n;
    if (obs_n > done_idx) done_idx = obs_n;
  endtask

  task automatic do_refresh();
    bit got = 1'b0;
    @(negedge clk);
    ref_req = 1'b1;
    model_ref();
    for (int k = 0; k < 200 && !got; k++) begin
      @(negedge clk);
      if (ref_ack) begin
        got = 1'b1;
        chk({cs_n, ras_n, cas_n, we_n} == 4'(C_REF), "R9", "ack with REFRESH",
            int'({cs_n, ras_n, cas_n, we_n}), C_REF);
        ref_req = 1'b0;
      end
    end
    chk(got, "R9", "ack seen", int'(got), 1);
    ref_req = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_open[i] = 1'b0; m_row[i] = 0; end
    repeat (3) @(negedge clk);
    chk(cke == 1'b0, "R1", "cke in reset", int'(cke), 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1", "pins in reset",
        int'({cs_n, ras_n, cas_n, we_n}), 15);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cke == 1'b1, "R1", "cke after reset", int'(cke), 1);
    chk({cs_n, ras_n, cas_n, we_n} == 4'(C_NOP), "R1", "NOP after reset",
        int'({cs_n, ras_n, cas_n, we_n}), C_NOP);
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);

    // R3: every bank starts closed
    for (int b = 0; b < 8; b++) send(b, b + 1, 3 * b + 1, b[0], 1'b0);
    verify("R3");
    // R4 / R11: same row in each bank hits
    for (int b = 0; b < 8; b++) send(b, b + 1, 5 + b, !b[0], 1'b0);
    verify("R4");
    // R5: different rows, auto-precharge on odd banks
    for (int b = 0; b < 8; b++) send(b, b + 9, b, b[0], b[0]);
    verify("R5");
    // R7: odd banks closed themselves, even banks still open
    for (int b = 0; b < 8; b++) send(b, b + 9, 7, 1'b0, 1'b0);
    verify("R7");
    // R9: refresh waits for the running request, then closes all banks
    begin
      int start = obs_n;
      send(2, 1, 2, 1'b1, 1'b0);
      while (obs_n == start) @(negedge clk);
      do_refresh();
    end
    verify("R9");
    // R9: refresh with no open bank
    do_refresh();
    verify("R9");
    // R9: table cleared, bank 2 must be activated again
    send(2, 1, 3, 1'b0, 1'b0);
    verify("R9");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule